// File: doc/BRIEF.md
# Gated-Window Frequency Counter

This block measures the frequency of a digital pulse train. The system clock is the reference. From it the block builds a timing window whose length is an exact number of clock cycles. It counts the rising edges of the measured signal while that window is open. When the window closes, the count goes into a result register and a new window starts on the next cycle, so measurements repeat without a break.

Three window lengths can be selected. Each one is set by a parameter as a cycle count, and the defaults equal one microsecond, one millisecond and one second. Because of this, the result reads directly in MHz, kHz or Hz. The measured signal is asynchronous to the clock, so it passes through a synchroniser and a rising-edge detector before it is counted. Shaping the analog signal and driving a display are left to other blocks.

Top module: `gated_freq_counter`

## Requirements
- R1: While reset is low, and on the first cycle after it, `count`, `resultValid` and `overflow` are all 0.
- R2: `winSel` selects the window length. 0 selects `WIN_US_CYC` cycles, 1 selects `WIN_MS_CYC`, and both 2 and 3 select `WIN_S_CYC`. Windows follow each other with no gap. `resultValid` is a one-cycle pulse, and consecutive pulses are exactly one window length apart.
- R3: The value shown with `resultValid` equals the number of rising edges of `sigIn` that occurred during the window.
- R4: A high level on `sigIn` counts once, however many cycles it lasts. A `sigIn` that stays at a constant level gives a count of 0.
- R5: If more than 2^CNT_W-1 edges arrive in one window, `count` saturates at all ones and `overflow` is 1. A window with exactly 2^CNT_W-1 edges gives that value with `overflow` at 0.
- R6: The edge counter clears at every window boundary. A steady input therefore gives the same result from each window, with no build-up across windows.
- R7: A change on `winSel` has no effect on the window that is already open. It sets the length of the next window only.
- R8: `count` and `overflow` hold their values between `resultValid` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; fixes the length of every window |
| rstN | input | 1 | Asynchronous reset, active low |
| sigIn | input | 1 | Pulse train to be measured, asynchronous to clk |
| winSel | input | 2 | Window length select: 0 short, 1 medium, 2 and 3 long |
| count | output | CNT_W | Edge count from the last completed window |
| resultValid | output | 1 | One-cycle pulse when a new result is loaded |
| overflow | output | 1 | Set when the last window's count saturated |

## Verification
The hardest case to reach is a selection change that arrives in the middle of a window. Its effect can only be seen one full window later, and only if the input is steady enough to make the counts predictable. The bench gets there with a square wave whose period divides every window length. With that wave, each steady window holds an exact whole number of edges. The bench then changes `winSel` a few cycles after a result and expects the old-length count once more before the new count appears. The saturation boundary is reached the same way: the long window holds exactly 255 edges at period 4 and 510 edges at period 2.

// File: rtl/fgc_pkg.sv
package fgc_pkg;

  // Window selection codes
  typedef enum logic [1:0] {
    SEL_MICRO    = 2'd0,
    SEL_MILLI    = 2'd1,
    SEL_UNIT     = 2'd2,
    SEL_UNIT_ALT = 2'd3
  } fgc_sel_e;

  // Strobes from window control to the datapath
  typedef struct packed {
    logic winOpen;   // a measurement window is running this cycle
    logic winClose;  // last cycle of the current window
  } fgc_strobe_t;

endpackage

// File: rtl/fgc_edge_sync.sv
module fgc_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sigIn,
  output logic edgePulse
);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   prevLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '0;
      prevLevel <= 1'b0;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], sigIn};
      prevLevel <= syncChain[SYNC_STAGES-1];
    end
  end

  assign edgePulse = syncChain[SYNC_STAGES-1] & ~prevLevel;

  // R4
  edge_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    edgePulse |=> !edgePulse);

endmodule

// File: rtl/fgc_window_ctrl.sv
module fgc_window_ctrl
  import fgc_pkg::*;
#(
  parameter int WIN_US_CYC = 100,
  parameter int WIN_MS_CYC = 100_000,
  parameter int WIN_S_CYC  = 100_000_000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  winSel,
  output fgc_strobe_t strobes
);

  localparam int MAX_LEN = (WIN_S_CYC > WIN_MS_CYC)
                         ? ((WIN_S_CYC > WIN_US_CYC) ? WIN_S_CYC : WIN_US_CYC)
                         : ((WIN_MS_CYC > WIN_US_CYC) ? WIN_MS_CYC : WIN_US_CYC);
  localparam int TMR_W = $clog2(MAX_LEN + 1);

  fgc_sel_e         activeSel;
  logic             started;
  logic [TMR_W-1:0] timer;
  logic [TMR_W-1:0] lastIdx;
  logic             lastCycle;

  // Terminal timer value for the selection that is in force
  always_comb begin
    unique case (activeSel)
      SEL_MICRO: lastIdx = TMR_W'(WIN_US_CYC - 1);
      SEL_MILLI: lastIdx = TMR_W'(WIN_MS_CYC - 1);
      default:   lastIdx = TMR_W'(WIN_S_CYC - 1);
    endcase
  end

  assign lastCycle = started && (timer == lastIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeSel <= SEL_MICRO;
      started   <= 1'b0;
      timer     <= '0;
    end else if (!started) begin
      // first window: take the selection and open
      activeSel <= fgc_sel_e'(winSel);
      started   <= 1'b1;
      timer     <= '0;
    end else if (lastCycle) begin
      // selection sampled only at the boundary
      activeSel <= fgc_sel_e'(winSel);
      timer     <= '0;
    end else begin
      timer     <= timer + 1'b1;
    end
  end

  assign strobes.winOpen  = started;
  assign strobes.winClose = lastCycle;

  // R2
  timer_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    timer <= lastIdx);

  // R7
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (started && !lastCycle) |=> $stable(activeSel));

endmodule

// File: rtl/fgc_datapath.sv
module fgc_datapath
  import fgc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  fgc_strobe_t      strobes,
  input  logic             edgePulse,
  output logic [CNT_W-1:0] result,
  output logic             resultValid,
  output logic             resultOvf
);

  logic [CNT_W-1:0] runCnt;
  logic             runOvf;
  logic             hit;
  logic             atMax;
  logic [CNT_W-1:0] cntNext;
  logic             ovfNext;

  assign hit     = strobes.winOpen && edgePulse;
  assign atMax   = &runCnt;
  assign cntNext = (hit && !atMax) ? runCnt + 1'b1 : runCnt;
  assign ovfNext = runOvf | (hit && atMax);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt      <= '0;
      runOvf      <= 1'b0;
      result      <= '0;
      resultOvf   <= 1'b0;
      resultValid <= 1'b0;
    end else if (strobes.winClose) begin
      result      <= cntNext;
      resultOvf   <= ovfNext;
      resultValid <= 1'b1;
      runCnt      <= '0;
      runOvf      <= 1'b0;
    end else begin
      resultValid <= 1'b0;
      runCnt      <= cntNext;
      runOvf      <= ovfNext;
    end
  end

  // R2
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> ($stable(result) && $stable(resultOvf)));

  // R5
  ovf_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultOvf |-> (&result));

  // R6
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.winClose |=> (runCnt == '0 && !runOvf));

endmodule

// File: rtl/gated_freq_counter.sv
module gated_freq_counter
  import fgc_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int WIN_US_CYC = 100,
  parameter int WIN_MS_CYC = 100_000,
  parameter int WIN_S_CYC  = 100_000_000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sigIn,
  input  logic [1:0]       winSel,
  output logic [CNT_W-1:0] count,
  output logic             resultValid,
  output logic             overflow
);

  fgc_strobe_t strobes;
  logic        edgePulse;

  fgc_edge_sync #(.SYNC_STAGES(2)) u_sync (
    .clk       (clk),
    .rstN      (rstN),
    .sigIn     (sigIn),
    .edgePulse (edgePulse)
  );

  fgc_window_ctrl #(
    .WIN_US_CYC (WIN_US_CYC),
    .WIN_MS_CYC (WIN_MS_CYC),
    .WIN_S_CYC  (WIN_S_CYC)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .winSel  (winSel),
    .strobes (strobes)
  );

  fgc_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .edgePulse   (edgePulse),
    .result      (count),
    .resultValid (resultValid),
    .resultOvf   (overflow)
  );

endmodule

// File: tb/gated_freq_counter_bench.sv
module gated_freq_counter_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W  = 8;
  localparam int WIN_US = 20;
  localparam int WIN_MS = 200;
  localparam int WIN_S  = 1020;

  typedef struct packed {
    logic [1:0]  sel;
    logic [15:0] period;
    logic [7:0]  expCnt;
    logic        expOvf;
    logic [15:0] expLen;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{2'd0, 16'd2,  8'd10,  1'b0, 16'd20},
    '{2'd0, 16'd5,  8'd4,   1'b0, 16'd20},
    '{2'd1, 16'd4,  8'd50,  1'b0, 16'd200},
    '{2'd1, 16'd10, 8'd20,  1'b0, 16'd200},
    '{2'd2, 16'd6,  8'd170, 1'b0, 16'd1020},
    '{2'd2, 16'd4,  8'd255, 1'b0, 16'd1020},
    '{2'd2, 16'd2,  8'd255, 1'b1, 16'd1020},
    '{2'd3, 16'd5,  8'd204, 1'b0, 16'd1020},
    '{2'd2, 16'd12, 8'd85,  1'b0, 16'd1020},
    '{2'd1, 16'd2,  8'd100, 1'b0, 16'd200}
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             sigIn = 1'b0;
  logic [1:0]       winSel = 2'd0;
  logic [CNT_W-1:0] count;
  logic             resultValid;
  logic             overflow;

  int checks = 0;
  int errors = 0;
  int period = 2;
  int phase = 0;
  bit stimOn = 1'b0;
  bit finished = 1'b0;

  gated_freq_counter #(
    .CNT_W      (CNT_W),
    .WIN_US_CYC (WIN_US),
    .WIN_MS_CYC (WIN_MS),
    .WIN_S_CYC  (WIN_S)
  ) u_gated_freq_counter (
    .clk         (clk),
    .rstN        (rstN),
    .sigIn       (sigIn),
    .winSel      (winSel),
    .count       (count),
    .resultValid (resultValid),
    .overflow    (overflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Square-wave source driven away from the active edge
  always @(negedge clk) begin
    if (stimOn) begin
      sigIn = (phase < period / 2);
      phase = (phase + 1 >= period) ? 0 : phase + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Waits for the next result pulse; returns cycles waited, -1 on timeout
  task automatic waitResult(output int cyc);
    int n = 0;
    begin
      @(negedge clk);
      n = 1;
      while (!resultValid && n < 5000) begin
        @(negedge clk);
        n++;
      end
      if (!resultValid) begin
        errors++;
        checks++;
        $display("FAIL watchdog: no result actual 0 expected 1");
        cyc = -1;
      end else cyc = n;
    end
  endtask

  // Waits for the next result and checks that count and overflow held (R8)
  task automatic waitHeld(output int cyc);
    int n = 0;
    logic [CNT_W-1:0] c0;
    logic o0;
    bit moved = 1'b0;
    begin
      c0 = count;
      o0 = overflow;
      @(negedge clk);
      n = 1;
      while (!resultValid && n < 5000) begin
        if (count != c0 || overflow != o0) moved = 1'b1;
        @(negedge clk);
        n++;
      end
      chk("R8 result held between pulses", int'(moved), 0);
      if (!resultValid) begin
        errors++;
        checks++;
        $display("FAIL watchdog: no result actual 0 expected 1");
        cyc = -1;
      end else cyc = n;
    end
  endtask

  task automatic setStim(input int p);
    @(negedge clk);
    period = p;
    phase = 0;
    stimOn = 1'b1;
  endtask

  initial begin
    int cyc;
    int firstCnt;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 count in reset", int'(count), 0);
    chk("R1 valid in reset", int'(resultValid), 0);
    chk("R1 overflow in reset", int'(overflow), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 count after reset", int'(count), 0);
    chk("R1 valid after reset", int'(resultValid), 0);

    // Vector table: R2 R3 R5 R6
    for (int i = 0; i < 10; i++) begin
      winSel = VECS[i].sel;
      setStim(int'(VECS[i].period));
      waitResult(cyc);
      waitResult(cyc);
      waitResult(cyc);
      chk($sformatf("R3/R5 count vec %0d", i), int'(count), int'(VECS[i].expCnt));
      chk($sformatf("R5 overflow vec %0d", i), int'(overflow), int'(VECS[i].expOvf));
      firstCnt = int'(count);
      waitHeld(cyc);
      chk($sformatf("R2 window length vec %0d", i), cyc, int'(VECS[i].expLen));
      chk($sformatf("R6 repeat count vec %0d", i), int'(count), firstCnt);
    end

    // R7: selection change mid-window is deferred
    winSel = 2'd0;
    setStim(5);
    waitResult(cyc);
    waitResult(cyc);
    waitResult(cyc);
    repeat (5) @(negedge clk);
    winSel = 2'd2;
    waitResult(cyc);
    chk("R7 open window keeps old length", int'(count), 4);
    chk("R7 open window spacing", cyc, 15);
    waitResult(cyc);
    chk("R7 next window uses new length", int'(count), 204);
    chk("R7 new window spacing", cyc, WIN_S);

    // R4: constant high level counts nothing
    winSel = 2'd0;
    @(negedge clk);
    stimOn = 1'b0;
    sigIn = 1'b1;
    waitResult(cyc);
    waitResult(cyc);
    waitResult(cyc);
    chk("R4 steady high gives zero", int'(count), 0);
    chk("R4 steady high no overflow", int'(overflow), 0);

    // R4: one long pulse counts once
    sigIn = 1'b0;
    waitResult(cyc);
    repeat (3) @(negedge clk);
    sigIn = 1'b1;
    repeat (8) @(negedge clk);
    sigIn = 1'b0;
    waitResult(cyc);
    chk("R4 long pulse counts once", int'(count), 1);

    // R1: reset in the middle of a run
    setStim(2);
    waitResult(cyc);
    repeat (4) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk("R1 count cleared by reset", int'(count), 0);
    chk("R1 overflow cleared by reset", int'(overflow), 0);
    chk("R1 valid cleared by reset", int'(resultValid), 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // Global watchdog
  initial begin
    repeat (150_000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule